// File: doc/BRIEF.md
# Quadrant Memory Chip-Select Decoder

This block sits between a processor's address-translation stage and a set of external static memories. It receives a 20-bit physical address with a read or write request. From these it drives active-low chip selects, output enables and write enables for those devices. The address space is split into four 256 KB quadrants, and the top two address bits select one. Each quadrant has its own 7-bit bank register. That register routes accesses in the quadrant to one of three chip selects and one of two enable pairs. It can also lock out writes, and it can flip address bits 16, 18 and 19 on the way out to the memories.

The outgoing address is combinational from the incoming address and the current bank settings. The strobes are registered, so they appear one clock after the request, in step with a single-cycle synchronisation stage. A simple write port loads the bank registers one quadrant at a time. Two quadrants may share a chip select and pair, so a single 512 KB device can span two quadrants.

Top module: `quad_mem_decoder`

## Requirements
- R1: A synchronous active-high reset drives every chip select, output enable and write enable high. It clears all four bank registers, so every quadrant then maps to chip select 0 and pair 0 with no address inversion.
- R2: The quadrant of an access is input address bits 19:18. Only that quadrant's bank register governs the access.
- R3: Bank register bits [1:0] hold a chip-select code. Codes 0 to 2 drive the matching chip select low for an access. Code 3 leaves every strobe high, including chip selects, output enables and write enables.
- R4: Bank register bit 2 picks enable pair 0 or 1. A read drives only the output enable of the chosen pair low, and every write enable stays high.
- R5: A write drives only the write enable of the chosen pair low, and every output enable stays high. Bank register bit 3 is a write lock: when it is set, a write still asserts the chip select but leaves every write enable high.
- R6: A request sampled at a rising clock edge produces its strobes during the following clock cycle only. A cycle without a request leaves every strobe high in the next cycle.
- R7: The output address equals the input address in the same cycle. The only exceptions are bit 16, inverted when bank bit 4 is set; bit 18, inverted when bank bit 5 is set; and bit 19, inverted when bank bit 6 is set.
- R8: If read and write are requested together, no strobe is asserted.
- R9: When the config write enable is high at a clock edge, the 7-bit config data is loaded into the bank register named by the 2-bit config select. An access sampled at that same edge still uses the previous contents.
- R10: Two quadrants programmed alike drive the same chip select and enable pair, so a single device can cover both quadrants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | 20 | Physical address from the translation stage |
| rd_req | input | 1 | Read request for this cycle |
| wr_req | input | 1 | Write request for this cycle |
| cfg_we | input | 1 | Bank register write enable |
| cfg_sel | input | 2 | Quadrant whose bank register is written |
| cfg_data | input | 7 | New bank register value |
| addr_out | output | 20 | Address to memories, with per-quadrant inversions |
| cs_n | output | 3 | Active-low chip selects |
| oe_n | output | 2 | Active-low output enables, one per pair |
| we_n | output | 2 | Active-low write enables, one per pair |

## Verification
Every cycle, the assertions check the following. At most one chip select is low. An output enable and a write enable are never low together, and an output enable never appears without a chip select. Idle, conflicting and write-locked requests leave the matching strobes high one cycle later. Bank registers change only on a matching config write. Only the bench's scenarios show that the right chip select and pair follow each quadrant's programmed value. They also show that the inverted address bits match the register fields, that two quadrants can share one device, and that a config write at the same edge as an access does not affect that access.

// File: rtl/qmd_pkg.sv
package qmd_pkg;
  localparam int QMD_ADDR_W = 20;
  localparam int QMD_NUM_QUAD = 4;
  localparam int QMD_NUM_CS = 3;
  localparam int QMD_NUM_PAIR = 2;
  localparam int QMD_CFG_W = 7;

  // Bank register layout, MSB first (bit 6 down to bit 0).
  typedef struct packed {
    logic       inv_hi;    // flip address bit 19
    logic       inv_mid;   // flip address bit 18
    logic       inv_lo;    // flip address bit 16
    logic       wr_lock;   // suppress write enables
    logic       pair_sel;  // enable pair 0 or 1
    logic [1:0] cs_code;   // chip select 0..2, 3 = none
  } bank_cfg_t;
endpackage

// File: rtl/qmd_bank_file.sv
module qmd_bank_file
  import qmd_pkg::*;
#(
  parameter int NUM_QUAD = QMD_NUM_QUAD,
  localparam int QW = $clog2(NUM_QUAD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [QW-1:0] wr_sel,
  input  bank_cfg_t     wr_cfg,
  input  logic [QW-1:0] rd_sel,
  output bank_cfg_t     rd_cfg
);
  bank_cfg_t bank_q [NUM_QUAD];

  for (genvar q = 0; q < NUM_QUAD; q++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q[q] <= '0;
      end else if (wr_en && (wr_sel == q[QW-1:0])) begin
        bank_q[q] <= wr_cfg;
      end
    end

    // R9: a matching write loads the register at the next edge
    a_r9_cfg_load: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_sel == q[QW-1:0])) |=> (bank_q[q] == $past(wr_cfg)));
    // R9: without a matching write the register holds
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (wr_sel == q[QW-1:0])) |=> $stable(bank_q[q]));
  end

  assign rd_cfg = bank_q[rd_sel];
endmodule

// File: rtl/qmd_addr_xlate.sv
module qmd_addr_xlate
  import qmd_pkg::*;
#(
  parameter int ADDR_W = QMD_ADDR_W,
  parameter int LO_BIT = 16,
  localparam int HI_BIT = ADDR_W - 1,
  localparam int MID_BIT = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  bank_cfg_t         cfg,
  output logic [ADDR_W-1:0] addr_out
);
  logic [ADDR_W-1:0] flip_mask;

  always_comb begin
    flip_mask = '0;
    flip_mask[HI_BIT]  = cfg.inv_hi;
    flip_mask[MID_BIT] = cfg.inv_mid;
    flip_mask[LO_BIT]  = cfg.inv_lo;
  end

  assign addr_out = addr_in ^ flip_mask;
endmodule

// File: rtl/qmd_strobe_gen.sv
module qmd_strobe_gen
  import qmd_pkg::*;
#(
  parameter int NUM_CS = QMD_NUM_CS,
  parameter int NUM_PAIR = QMD_NUM_PAIR
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_req,
  input  logic                wr_req,
  input  bank_cfg_t           cfg,
  output logic [NUM_CS-1:0]   cs_n,
  output logic [NUM_PAIR-1:0] oe_n,
  output logic [NUM_PAIR-1:0] we_n
);
  logic rd_only, wr_only, has_dev;
  logic [NUM_CS-1:0]   cs_act;
  logic [NUM_PAIR-1:0] oe_act, we_act;

  assign rd_only = rd_req && !wr_req;
  assign wr_only = wr_req && !rd_req;
  assign has_dev = (int'(cfg.cs_code) < NUM_CS);

  for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
    assign cs_act[c] = (rd_only || wr_only) && (int'(cfg.cs_code) == c);
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    logic pair_hit;
    assign pair_hit  = has_dev && (int'(cfg.pair_sel) == p);
    assign oe_act[p] = rd_only && pair_hit;
    assign we_act[p] = wr_only && pair_hit && !cfg.wr_lock;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n <= '1;
      oe_n <= '1;
      we_n <= '1;
    end else begin
      cs_n <= ~cs_act;
      oe_n <= ~oe_act;
      we_n <= ~we_act;
    end
  end

  // R3: never more than one chip select low
  a_r3_cs_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  // R4: read and write enables never overlap
  a_r4_oe_we_excl: assert property (@(posedge clk) disable iff (rst)
    !((|(~oe_n)) && (|(~we_n))));
  // R4: an output enable comes with a chip select
  a_r4_oe_has_cs: assert property (@(posedge clk) disable iff (rst)
    (|(~oe_n)) |-> (|(~cs_n)));
  // R6: no request means all strobes high next cycle
  a_r6_idle_high: assert property (@(posedge clk) disable iff (rst)
    (!rd_req && !wr_req) |=> ((&cs_n) && (&oe_n) && (&we_n)));
  // R5: locked write leaves write enables high
  a_r5_lock_we: assert property (@(posedge clk) disable iff (rst)
    (wr_only && cfg.wr_lock) |=> (&we_n));
  // R8: conflicting request asserts no chip select
  a_r8_conflict: assert property (@(posedge clk) disable iff (rst)
    (rd_req && wr_req) |=> (&cs_n));
endmodule

// File: rtl/quad_mem_decoder.sv
module quad_mem_decoder
  import qmd_pkg::*;
#(
  parameter int ADDR_W = QMD_ADDR_W,
  parameter int NUM_CS = QMD_NUM_CS,
  parameter int NUM_PAIR = QMD_NUM_PAIR,
  parameter int LO_BIT = 16,
  localparam int NUM_QUAD = QMD_NUM_QUAD,
  localparam int QW = $clog2(NUM_QUAD)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr_in,
  input  logic                 rd_req,
  input  logic                 wr_req,
  input  logic                 cfg_we,
  input  logic [QW-1:0]        cfg_sel,
  input  logic [QMD_CFG_W-1:0] cfg_data,
  output logic [ADDR_W-1:0]    addr_out,
  output logic [NUM_CS-1:0]    cs_n,
  output logic [NUM_PAIR-1:0]  oe_n,
  output logic [NUM_PAIR-1:0]  we_n
);
  bank_cfg_t       cur_cfg;
  logic [QW-1:0]   quad;

  assign quad = addr_in[ADDR_W-1 -: QW];

  qmd_bank_file #(.NUM_QUAD(NUM_QUAD)) u_banks (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_we),
    .wr_sel (cfg_sel),
    .wr_cfg (bank_cfg_t'(cfg_data)),
    .rd_sel (quad),
    .rd_cfg (cur_cfg)
  );

  qmd_addr_xlate #(.ADDR_W(ADDR_W), .LO_BIT(LO_BIT)) u_xlate (
    .addr_in  (addr_in),
    .cfg      (cur_cfg),
    .addr_out (addr_out)
  );

  qmd_strobe_gen #(.NUM_CS(NUM_CS), .NUM_PAIR(NUM_PAIR)) u_strobe (
    .clk    (clk),
    .rst    (rst),
    .rd_req (rd_req),
    .wr_req (wr_req),
    .cfg    (cur_cfg),
    .cs_n   (cs_n),
    .oe_n   (oe_n),
    .we_n   (we_n)
  );

  // R7: address bits outside 16, 18 and 19 pass untouched
  a_r7_passthru: assert property (@(posedge clk) disable iff (rst)
    (addr_out[LO_BIT-1:0] == addr_in[LO_BIT-1:0]) &&
    (addr_out[ADDR_W-3:LO_BIT+1] == addr_in[ADDR_W-3:LO_BIT+1]));
endmodule

// File: tb/test_quad_mem_decoder.sv
module test_quad_mem_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] addr_in = '0;
  logic        rd_req = 1'b0, wr_req = 1'b0, cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [6:0]  cfg_data = '0;
  logic [19:0] addr_out;
  logic [2:0]  cs_n;
  logic [1:0]  oe_n, we_n;

  always #4 clk = ~clk;

  quad_mem_decoder i_quad_mem_decoder (
    .clk(clk), .rst(rst), .addr_in(addr_in), .rd_req(rd_req), .wr_req(wr_req),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .addr_out(addr_out), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n)
  );

  typedef struct {
    logic [6:0] strb;
    string      tag;
  } exp_t;

  exp_t       sbq[$];
  exp_t       mon_e;
  logic [6:0] mdl[4];
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 0;

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected strobes {cs_n, oe_n, we_n} from the requirements
  function automatic logic [6:0] exp_strb(input logic rd, input logic wr, input logic [6:0] c);
    logic [2:0] cs = 3'b111;
    logic [1:0] oe = 2'b11, we = 2'b11;
    if ((rd != wr) && (c[1:0] != 2'd3)) begin
      cs[c[1:0]] = 1'b0;
      if (rd) oe[c[2]] = 1'b0;
      else if (!c[3]) we[c[2]] = 1'b0;
    end
    return {cs, oe, we};
  endfunction

  function automatic logic [19:0] exp_addr(input logic [19:0] a, input logic [6:0] c);
    return a ^ {c[6], c[5], 1'b0, c[4], 16'h0};
  endfunction

  // Driver: one cycle of stimulus, pushes expected strobes for next cycle
  task automatic cyc(input logic rd, input logic wr, input logic [19:0] a,
                     input logic cw, input logic [1:0] cs, input logic [6:0] cd,
                     input string tag);
    exp_t e;
    @(negedge clk);
    rd_req = rd; wr_req = wr; addr_in = a;
    cfg_we = cw; cfg_sel = cs; cfg_data = cd;
    e.strb = exp_strb(rd, wr, mdl[a[19:18]]);
    e.tag = tag;
    sbq.push_back(e);
    #1;
    cmp({tag, " R7 addr"}, {12'h0, addr_out}, {12'h0, exp_addr(a, mdl[a[19:18]])});
    @(posedge clk);
    if (cw) mdl[cs] = cd;
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 20'h0, 1'b0, 2'd0, 7'h0, tag);
  endtask

  task automatic prog(input logic [1:0] q, input logic [6:0] v);
    cyc(1'b0, 1'b0, 20'h0, 1'b1, q, v, "R9 prog");
  endtask

  // Monitor: pops and compares after each edge
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      mon_e = sbq.pop_front();
      cmp({mon_e.tag, " strobes"}, {25'h0, cs_n, oe_n, we_n}, {25'h0, mon_e.strb});
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int q = 0; q < 4; q++) mdl[q] = 7'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1 reset strobes", {25'h0, cs_n, oe_n, we_n}, 32'h7F);
    rst = 1'b0;
    // R1: cleared banks map everything to CS0 / pair 0, no inversion
    cyc(1'b1, 1'b0, 20'hD1234, 1'b0, 2'd0, 7'h0, "R1 default read q3");
    cyc(1'b0, 1'b1, 20'h91234, 1'b0, 2'd0, 7'h0, "R1 default write q2");
    idle("R6 idle");
    prog(2'd0, 7'h00);
    prog(2'd1, 7'h00);
    prog(2'd2, 7'h25);   // cs1, pair1, flip bit 18
    prog(2'd3, 7'h5E);   // cs2, pair1, lock, flip 16 and 19
    // R10: one device over two quadrants
    cyc(1'b0, 1'b1, 20'h00010, 1'b0, 2'd0, 7'h0, "R10 write q0");
    cyc(1'b0, 1'b1, 20'h4ABCD, 1'b0, 2'd0, 7'h0, "R10 write q1");
    cyc(1'b1, 1'b0, 20'h7FFFF, 1'b0, 2'd0, 7'h0, "R10 read q1");
    // R4, R7
    cyc(1'b1, 1'b0, 20'h800FF, 1'b0, 2'd0, 7'h0, "R4 read q2 pair1");
    // R5
    cyc(1'b0, 1'b1, 20'hF0000, 1'b0, 2'd0, 7'h0, "R5 locked write q3");
    cyc(1'b0, 1'b1, 20'hB5555, 1'b0, 2'd0, 7'h0, "R5 write q2 pair1");
    cyc(1'b1, 1'b0, 20'hC1234, 1'b0, 2'd0, 7'h0, "R4 read q3 locked ok");
    // R8
    cyc(1'b1, 1'b1, 20'h80000, 1'b0, 2'd0, 7'h0, "R8 read+write q2");
    idle("R6 idle after conflict");
    // R3: code 3 leaves everything high
    prog(2'd1, 7'h07);
    cyc(1'b1, 1'b0, 20'h40000, 1'b0, 2'd0, 7'h0, "R3 no-device read q1");
    cyc(1'b0, 1'b1, 20'h7FFFF, 1'b0, 2'd0, 7'h0, "R3 no-device write q1");
    // R9: same-edge write does not affect access
    cyc(1'b1, 1'b0, 20'h01000, 1'b1, 2'd0, 7'h76, "R9 same-edge read q0");
    cyc(1'b1, 1'b0, 20'h01000, 1'b0, 2'd0, 7'h0, "R9 next read q0");
    // R2: quadrant boundaries, back-to-back (R6)
    for (int q = 0; q < 4; q++) begin
      cyc(1'b1, 1'b0, {q[1:0], 18'h3FFFF}, 1'b0, 2'd0, 7'h0, "R2 top of quadrant");
      cyc(1'b0, 1'b1, {q[1:0], 18'h00000}, 1'b0, 2'd0, 7'h0, "R2 base of quadrant");
    end
    idle("R6 trailing idle");
    idle("R6 trailing idle");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule